// File: doc/BRIEF.md
# In-Lane Quad-Element Vector Permute Unit

This block reorders the elements of a source vector of up to 512 bits without letting any element leave its 128-bit lane. Each lane holds four elements, and each destination element picks one of the four elements of its own lane. The 2-bit pick for an element comes from one of two places. It can come from an 8-bit immediate that every lane shares. It can also come from the low two bits of the matching element of a control vector. Element contents are treated as raw bits.

Around the selection the block handles the operand and the write. A single memory element can be broadcast into every position of the data operand (immediate mode) or of the control operand (variable mode). Writes can be masked per element, with either merge or zero behaviour. Only the active vector length is written: 1, 2 or 4 lanes. Everything above the active length reads back as zero. The block also flags illegal encodings.

One operation is accepted per cycle. Its result appears one clock later, together with a valid strobe, a fault flag and a write enable.

Top module: `laneQuadPermute`

## Requirements
- R1: With `useVarCtrl`=0, destination element k of every lane (k = 0..3) takes the lane's source element numbered `imm8[2k+1:2k]`. Element n of a lane occupies bits [32n+31:32n] of that lane, counted from the lane's lowest bit. All lanes use the same four immediate fields.
- R2: With `useVarCtrl`=1, each destination element takes its pick from bits [1:0] of the control element at the same position. All other bits of a control element have no effect.
- R3: A destination element only ever receives an element from the 128-bit lane that contains its own position.
- R4: When `bcastEn`=1 and `srcFromMem`=1 on a masked-encoding operation, element 0 of `srcData` stands in for every source element in immediate mode. In variable mode, element 0 of `ctrlVec` stands in for every control element instead. When `srcFromMem`=0, `bcastEn` has no effect.
- R5: When `maskEn`=1, an active element whose `wrMask` bit is 0 keeps its `oldDest` value if `zeroMode`=0, and becomes zero if `zeroMode`=1. When `maskEn`=0, every active element is written with its permuted value.
- R6: `lenCode` 0, 1 and 2 select 4, 8 and 16 active elements. Every element above the active length is output as zero, whatever the mask says.
- R7: An operation faults in any of three cases: in immediate mode when `regSpec` is not 4'b1111; on the legacy encoding (`legacyEnc`=1) when `wBit`=1; and for any length code above what the configured width holds (code 3 at the default width).
- R8: A faulting operation gives `outFault`=1 and `outWe`=0, and leaves `outDest` at its previous value.
- R9: `outValid` equals `inValid` from the previous cycle, and a non-faulting valid operation updates `outDest` on that same edge. Cycles without `inValid` leave `outDest` unchanged. Synchronous reset clears `outValid`, `outFault`, `outWe` and `outDest`.
- R10: On the legacy encoding, `maskEn` and `bcastEn` have no effect: all active elements are written and no broadcast takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| srcData | input | ELEM_W*4*NUM_LANES | Data source vector |
| ctrlVec | input | ELEM_W*4*NUM_LANES | Per-element control vector |
| imm8 | input | 8 | Shared immediate selects |
| oldDest | input | ELEM_W*4*NUM_LANES | Prior destination, used for merging |
| wrMask | input | 4*NUM_LANES | Per-element write mask |
| useVarCtrl | input | 1 | 1: variable control, 0: immediate control |
| lenCode | input | 2 | Active length: 0=1 lane, 1=2 lanes, 2=4 lanes |
| bcastEn | input | 1 | Broadcast request |
| srcFromMem | input | 1 | Broadcast operand comes from memory |
| maskEn | input | 1 | Enable write masking |
| zeroMode | input | 1 | Masked-off elements: 1 zero, 0 merge |
| legacyEnc | input | 1 | Legacy (unmasked) encoding |
| regSpec | input | 4 | Second-register specifier field |
| wBit | input | 1 | Width bit of the encoding |
| outValid | output | 1 | Result valid |
| outFault | output | 1 | Illegal-encoding fault |
| outWe | output | 1 | Result written |
| outDest | output | ELEM_W*4*NUM_LANES | Destination vector |

## Verification
The bench builds the unit with 8-bit elements and the full four lanes. This keeps a whole vector at 128 bits while leaving the lane structure and all three lengths intact. At that size every one of the 256 immediates can be swept, and so can 256 variable control patterns whose upper control bits carry noise. It also sweeps 256 complementary mask patterns in both merge and zero modes. Each case is compared with an element-by-element model. Broadcast, length limits, the legacy encoding and every fault cause are driven as directed cases. After each fault, the bench checks that the held destination is intact.

// File: rtl/permPkg.sv
package permPkg;
  localparam int LANE_ELEMS = 4;
  localparam int SEL_W      = 2;

  typedef struct packed {
    logic fault;
    logic useVar;
    logic bcastData;
    logic bcastCtl;
    logic zeroFill;
  } permStrobes_t;
endpackage

// File: rtl/permCtrl.sv
module permCtrl
  import permPkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int MAX_ELEMS = NUM_LANES * LANE_ELEMS
) (
  input  logic                 useVarCtrl,
  input  logic [1:0]           lenCode,
  input  logic                 bcastEn,
  input  logic                 srcFromMem,
  input  logic                 maskEn,
  input  logic                 zeroMode,
  input  logic                 legacyEnc,
  input  logic [3:0]           regSpec,
  input  logic                 wBit,
  input  logic [MAX_ELEMS-1:0] wrMask,
  output permStrobes_t         strobes,
  output logic [MAX_ELEMS-1:0] activeMask,
  output logic [MAX_ELEMS-1:0] takeNew
);
  logic [3:0] activeLanes;
  logic       lenBad;
  logic       maskOn;
  logic       bcastOn;

  always_comb begin
    activeLanes = 4'd1 << lenCode;
    lenBad      = (32'(activeLanes) > NUM_LANES);
    maskOn      = maskEn & ~legacyEnc;
    bcastOn     = bcastEn & srcFromMem & ~legacyEnc;

    strobes.fault     = (~useVarCtrl & (regSpec != 4'hF)) | (legacyEnc & wBit) | lenBad;
    strobes.useVar    = useVarCtrl;
    strobes.bcastData = bcastOn & ~useVarCtrl;
    strobes.bcastCtl  = bcastOn & useVarCtrl;
    strobes.zeroFill  = zeroMode;
  end

  for (genvar e = 0; e < MAX_ELEMS; e++) begin : g_elemCtl
    localparam int LANE = e / LANE_ELEMS;
    assign activeMask[e] = (LANE < 32'(activeLanes));
    assign takeNew[e]    = ~maskOn | wrMask[e];
  end
endmodule

// File: rtl/permData.sv
module permData
  import permPkg::*;
#(
  parameter int ELEM_W    = 32,
  parameter int NUM_LANES = 4,
  localparam int MAX_ELEMS = NUM_LANES * LANE_ELEMS,
  localparam int VEC_W     = MAX_ELEMS * ELEM_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  permStrobes_t         strobes,
  input  logic [MAX_ELEMS-1:0] activeMask,
  input  logic [MAX_ELEMS-1:0] takeNew,
  input  logic [VEC_W-1:0]     srcData,
  input  logic [VEC_W-1:0]     ctrlVec,
  input  logic [7:0]           imm8,
  input  logic [VEC_W-1:0]     oldDest,
  output logic                 outValid,
  output logic                 outFault,
  output logic                 outWe,
  output logic [VEC_W-1:0]     outDest
);
  logic [ELEM_W-1:0] effSrc [MAX_ELEMS];
  logic [VEC_W-1:0]  nextDest;

  for (genvar e = 0; e < MAX_ELEMS; e++) begin : g_elem
    localparam int LANE = e / LANE_ELEMS;
    localparam int POS  = e % LANE_ELEMS;
    logic [SEL_W-1:0]  ctlSel;
    logic [SEL_W-1:0]  sel;
    logic [ELEM_W-1:0] picked;
    logic [ELEM_W-1:0] oldEl;

    assign effSrc[e] = strobes.bcastData ? srcData[ELEM_W-1:0]
                                         : srcData[e*ELEM_W +: ELEM_W];
    assign ctlSel    = strobes.bcastCtl ? ctrlVec[SEL_W-1:0]
                                        : ctrlVec[e*ELEM_W +: SEL_W];
    assign sel       = strobes.useVar ? ctlSel : imm8[POS*SEL_W +: SEL_W];
    assign picked    = effSrc[LANE*LANE_ELEMS + 32'(sel)];
    assign oldEl     = oldDest[e*ELEM_W +: ELEM_W];

    always_comb begin
      if (!activeMask[e])        nextDest[e*ELEM_W +: ELEM_W] = '0;
      else if (takeNew[e])       nextDest[e*ELEM_W +: ELEM_W] = picked;
      else if (strobes.zeroFill) nextDest[e*ELEM_W +: ELEM_W] = '0;
      else                       nextDest[e*ELEM_W +: ELEM_W] = oldEl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outFault <= 1'b0;
      outWe    <= 1'b0;
      outDest  <= '0;
    end else begin
      outValid <= inValid;
      outFault <= inValid & strobes.fault;
      outWe    <= inValid & ~strobes.fault;
      if (inValid && !strobes.fault) outDest <= nextDest;
    end
  end
endmodule

// File: rtl/laneQuadPermute.sv
module laneQuadPermute
  import permPkg::*;
#(
  parameter int ELEM_W    = 32,
  parameter int NUM_LANES = 4,
  localparam int MAX_ELEMS = NUM_LANES * LANE_ELEMS,
  localparam int VEC_W     = MAX_ELEMS * ELEM_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [VEC_W-1:0]     srcData,
  input  logic [VEC_W-1:0]     ctrlVec,
  input  logic [7:0]           imm8,
  input  logic [VEC_W-1:0]     oldDest,
  input  logic [MAX_ELEMS-1:0] wrMask,
  input  logic                 useVarCtrl,
  input  logic [1:0]           lenCode,
  input  logic                 bcastEn,
  input  logic                 srcFromMem,
  input  logic                 maskEn,
  input  logic                 zeroMode,
  input  logic                 legacyEnc,
  input  logic [3:0]           regSpec,
  input  logic                 wBit,
  output logic                 outValid,
  output logic                 outFault,
  output logic                 outWe,
  output logic [VEC_W-1:0]     outDest
);
  permStrobes_t         strobes;
  logic [MAX_ELEMS-1:0] activeMask;
  logic [MAX_ELEMS-1:0] takeNew;

  permCtrl #(.NUM_LANES(NUM_LANES)) u_ctrl (
    .useVarCtrl(useVarCtrl), .lenCode(lenCode), .bcastEn(bcastEn),
    .srcFromMem(srcFromMem), .maskEn(maskEn), .zeroMode(zeroMode),
    .legacyEnc(legacyEnc), .regSpec(regSpec), .wBit(wBit), .wrMask(wrMask),
    .strobes(strobes), .activeMask(activeMask), .takeNew(takeNew)
  );

  permData #(.ELEM_W(ELEM_W), .NUM_LANES(NUM_LANES)) u_data (
    .clk(clk), .rst(rst), .inValid(inValid), .strobes(strobes),
    .activeMask(activeMask), .takeNew(takeNew), .srcData(srcData),
    .ctrlVec(ctrlVec), .imm8(imm8), .oldDest(oldDest),
    .outValid(outValid), .outFault(outFault), .outWe(outWe), .outDest(outDest)
  );
endmodule

// File: rtl/laneQuadPermuteChk.sv
module laneQuadPermuteChk #(
  parameter int ELEM_W    = 32,
  parameter int NUM_LANES = 4,
  localparam int LANE_W   = 4 * ELEM_W,
  localparam int VEC_W    = NUM_LANES * LANE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             useVarCtrl,
  input logic [1:0]       lenCode,
  input logic             legacyEnc,
  input logic [3:0]       regSpec,
  input logic             wBit,
  input logic             outValid,
  input logic             outFault,
  input logic             outWe,
  input logic [VEC_W-1:0] outDest
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);                                           // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !outWe && $stable(outDest)));         // R9
  AST_WE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    outWe |-> (outValid && !outFault));                              // R8
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    outFault |-> (!outWe && $stable(outDest)));                      // R8
  AST_IMM_SPEC_FAULT: assert property (@(posedge clk) disable iff (rst)
    (inValid && !useVarCtrl && regSpec != 4'hF) |=> outFault);       // R7
  AST_LEGACY_W_FAULT: assert property (@(posedge clk) disable iff (rst)
    (inValid && legacyEnc && wBit) |=> outFault);                    // R7
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (inValid && lenCode == 2'd0) |=> (outFault || outDest[VEC_W-1:LANE_W] == '0)); // R6
endmodule

bind laneQuadPermute laneQuadPermuteChk #(.ELEM_W(ELEM_W), .NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .useVarCtrl(useVarCtrl),
  .lenCode(lenCode), .legacyEnc(legacyEnc), .regSpec(regSpec), .wBit(wBit),
  .outValid(outValid), .outFault(outFault), .outWe(outWe), .outDest(outDest)
);

// File: tb/laneQuadPermute_bench.sv
`timescale 1ns/1ps
module laneQuadPermute_bench;
  localparam int EW = 8;
  localparam int NL = 4;
  localparam int NE = NL * 4;
  localparam int MW = NE * EW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [MW-1:0] srcData = '0, ctrlVec = '0, oldDest = '0;
  logic [7:0] imm8 = '0;
  logic [NE-1:0] wrMask = '0;
  logic useVarCtrl = 1'b0, bcastEn = 1'b0, srcFromMem = 1'b0;
  logic maskEn = 1'b0, zeroMode = 1'b0, legacyEnc = 1'b0, wBit = 1'b0;
  logic [1:0] lenCode = 2'd2;
  logic [3:0] regSpec = 4'hF;
  logic outValid, outFault, outWe;
  logic [MW-1:0] outDest;

  int checks = 0, fails = 0;
  logic [MW-1:0] expDest = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  laneQuadPermute #(.ELEM_W(EW), .NUM_LANES(NL)) u_laneQuadPermute (
    .clk(clk), .rst(rst), .inValid(inValid), .srcData(srcData), .ctrlVec(ctrlVec),
    .imm8(imm8), .oldDest(oldDest), .wrMask(wrMask), .useVarCtrl(useVarCtrl),
    .lenCode(lenCode), .bcastEn(bcastEn), .srcFromMem(srcFromMem), .maskEn(maskEn),
    .zeroMode(zeroMode), .legacyEnc(legacyEnc), .regSpec(regSpec), .wBit(wBit),
    .outValid(outValid), .outFault(outFault), .outWe(outWe), .outDest(outDest)
  );

  task automatic check(bit ok, string req, logic [MW-1:0] act, logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit modelFault();
    return (!useVarCtrl && regSpec != 4'hF) || (legacyEnc && wBit) || (lenCode == 2'd3);
  endfunction

  function automatic logic [MW-1:0] modelDest();
    logic [MW-1:0] r = '0;
    bit maskOn = maskEn && !legacyEnc;
    bit bc = bcastEn && srcFromMem && !legacyEnc;
    for (int e = 0; e < NE; e++) begin
      int lane = e / 4;
      int k = e % 4;
      int s;
      logic [EW-1:0] v;
      if (useVarCtrl) s = (bc ? int'(ctrlVec[EW-1:0]) : int'(ctrlVec[e*EW +: EW])) % 4;
      else s = (int'(imm8) >> (2*k)) % 4;
      v = (bc && !useVarCtrl) ? srcData[EW-1:0] : srcData[(lane*4+s)*EW +: EW];
      if (lane >= (1 << lenCode)) r[e*EW +: EW] = '0;
      else if (!maskOn || wrMask[e]) r[e*EW +: EW] = v;
      else if (zeroMode) r[e*EW +: EW] = '0;
      else r[e*EW +: EW] = oldDest[e*EW +: EW];
    end
    return r;
  endfunction

  // inputs already set; drive strobe for one cycle and check the result
  task automatic runOp(string req);
    bit f = modelFault();
    logic [MW-1:0] nd = modelDest();
    @(negedge clk); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    check(outValid === 1'b1, {req, " R9 valid"}, MW'(outValid), MW'(1));
    if (f) begin
      check(outFault === 1'b1 && outWe === 1'b0, {req, " R7 fault flag"},
            MW'({outFault, outWe}), MW'(2));
      check(outDest === expDest, {req, " R8 dest held"}, outDest, expDest);
    end else begin
      check(outFault === 1'b0 && outWe === 1'b1, {req, " write flags"},
            MW'({outFault, outWe}), MW'(1));
      check(outDest === nd, req, outDest, nd);
      expDest = nd;
    end
  endtask

  task automatic defaults();
    useVarCtrl = 0; bcastEn = 0; srcFromMem = 0; maskEn = 0; zeroMode = 0;
    legacyEnc = 0; wBit = 0; lenCode = 2'd2; regSpec = 4'hF; wrMask = '0;
    for (int e = 0; e < NE; e++) begin
      srcData[e*EW +: EW] = EW'(e * 17 + 3);
      oldDest[e*EW +: EW] = EW'(8'hA0 + e);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R9)
    check(outValid === 0 && outFault === 0 && outWe === 0, "R9 reset flags",
          MW'({outValid, outFault, outWe}), '0);
    check(outDest === '0, "R9 reset dest", outDest, '0);

    // R1 and R3: every immediate, full length
    for (int i = 0; i < 256; i++) begin
      imm8 = 8'(i);
      runOp("R1 R3 immediate sweep");
    end

    // R2: variable control, noise in upper control bits
    useVarCtrl = 1; regSpec = 4'h3;
    for (int p = 0; p < 256; p++) begin
      for (int e = 0; e < NE; e++)
        ctrlVec[e*EW +: EW] = EW'((((p >> (e % 4 * 2)) + e / 4) % 4) | ((p * 7 + e * 13) << 2));
      runOp("R2 R3 variable sweep");
    end

    // R4 broadcast
    defaults(); imm8 = 8'h1B; bcastEn = 1; srcFromMem = 1;
    runOp("R4 imm data broadcast");
    srcFromMem = 0; runOp("R4 broadcast without memory");
    useVarCtrl = 1; srcFromMem = 1;
    for (int e = 0; e < NE; e++) ctrlVec[e*EW +: EW] = EW'(e * 5 + 2);
    runOp("R4 var control broadcast");

    // R5 masks, merge and zero
    defaults(); imm8 = 8'hE4; maskEn = 1;
    for (int z = 0; z < 2; z++) begin
      zeroMode = z[0];
      for (int m = 0; m < 256; m++) begin
        wrMask = {8'(m), ~8'(m)};
        imm8 = 8'(m * 37);
        runOp("R5 mask sweep");
      end
    end

    // R6 lengths
    for (int l = 0; l < 3; l++) begin
      defaults(); imm8 = 8'h72; lenCode = 2'(l); maskEn = 1; wrMask = 16'hFFFF;
      runOp("R6 length");
      zeroMode = 0; wrMask = 16'h5A5A; runOp("R6 length with merge");
    end

    // R7 and R8 faults
    defaults(); imm8 = 8'h39; regSpec = 4'h7; runOp("R7 imm specifier fault");
    defaults(); useVarCtrl = 1; regSpec = 4'h0; runOp("R7 var specifier ok");
    defaults(); legacyEnc = 1; wBit = 1; runOp("R7 legacy W fault");
    defaults(); wBit = 1; imm8 = 8'h4E; runOp("R7 masked encoding W ok");
    defaults(); lenCode = 2'd3; runOp("R7 bad length fault");

    // R10 legacy ignores mask and broadcast
    defaults(); legacyEnc = 1; maskEn = 1; zeroMode = 1; wrMask = '0;
    bcastEn = 1; srcFromMem = 1; imm8 = 8'hB1; runOp("R10 legacy ignores mask/bcast");

    // R9 idle cycles hold
    repeat (2) @(negedge clk);
    check(outValid === 0 && outWe === 0, "R9 idle flags", MW'({outValid, outWe}), '0);
    check(outDest === expDest, "R9 idle dest held", outDest, expDest);

    finishRun();
  end
endmodule